// File: doc/BRIEF.md
# Block Address Translation Matcher

This block keeps a small file of block translation entries and matches every memory access against them. Each entry is a pair of 32-bit words: an upper word that holds the effective block address, the block length and the validity bits, and a lower word that holds the real block address and the access permission. There are two banks of entries. Instruction fetches are matched against one bank and all other accesses against the other.

For each access the block takes a 32-bit effective address, a fetch/data select and a user/supervisor flag. It builds a size mask for every entry, qualifies each entry for the current privilege, and reports the lowest-numbered entry that matches. The outputs are a hit flag, the index of that entry, the real address cut to its 4 KB page, and read/write/execute permission bits. The lookup path has no registers.

A static mode input selects an older register layout. In that layout validity is a single bit in the lower word, the length field moves to the lower word, and the upper word carries a two-key page protection code. Entries are loaded through an indexed write port. Reset clears every entry.

Top module: `blk_xlate`

## Requirements
- R1: An access with `fetch_i`=1 is matched only against the instruction bank (`wr_bank_i`=1). Any other access is matched only against the data bank (`wr_bank_i`=0).
- R2: When several entries of the selected bank match, `hit_idx_o` reports the lowest index and the address and permission come from that entry.
- R3: In the standard layout, upper bit 1 enables an entry for supervisor accesses (`user_i`=0) and upper bit 0 enables it for user accesses (`user_i`=1). An entry that is not enabled never matches.
- R4: In the standard layout the block mask is 0xFFFE0000 with the bits of (upper AND 0x1FFC) shifted left by 15 removed. An entry matches when (EA AND mask) equals (upper AND 0xFFFE0000).
- R5: On a hit, `ra_o` = ((lower AND mask) OR (EA AND NOT mask)) AND 0xFFFFF000.
- R6: In the standard layout, lower bits [1:0] set the permission: 00 gives none, 10 gives read+write+execute, and 01 or 11 gives read+execute. `perm_o` bit 0 is read, bit 1 is write, bit 2 is execute.
- R7: With `legacy_i`=1, lower bit 6 is the only validity bit and applies to both privileges. The length field is lower bits [5:0], shifted left by 17 to build the mask. The match and the address otherwise follow R4 and R5.
- R8: With `legacy_i`=1, upper bits [1:0] are the protection code and the key is upper bit 3 for supervisor or upper bit 2 for user. With key 0: codes 00, 01 and 10 give read+write and 11 gives read. With key 1: 00 gives nothing, 01 and 11 give read, 10 gives read+write. Execute is always granted.
- R9: A write with `wr_en_i`=1 replaces only the word chosen by `wr_bank_i`, `wr_idx_i` and `wr_hi_i` (1 = upper word). All other words keep their values.
- R10: After reset every entry is zero, so no access hits in either layout.
- R11: On a miss, `hit_o`, `hit_idx_o`, `ra_o` and `perm_o` are all zero.
- R12: The lookup outputs follow `ea_i`, `fetch_i`, `user_i` and `legacy_i` in the same cycle. A register write is seen by lookups only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| legacy_i | input | 1 | Selects the older register layout |
| wr_en_i | input | 1 | Register write strobe |
| wr_bank_i | input | 1 | Write bank: 1 instruction, 0 data |
| wr_idx_i | input | IDX_W | Entry index for the write |
| wr_hi_i | input | 1 | 1 writes the upper word, 0 the lower word |
| wr_data_i | input | 32 | Write data |
| ea_i | input | 32 | Effective address |
| fetch_i | input | 1 | 1 for an instruction fetch |
| user_i | input | 1 | 1 for user state, 0 for supervisor |
| hit_o | output | 1 | An entry matched |
| hit_idx_o | output | IDX_W | Index of the winning entry |
| ra_o | output | 32 | Real page address, low 12 bits zero |
| perm_o | output | 3 | Permission {execute, write, read} |

## Verification
The assertions assume that `legacy_i` is a static configuration pin. The stable-storage property allows it to change between writes, and the bench changes it only between whole test phases. They also assume the write inputs are known whenever `wr_en_i` is high. The bench drives all write fields together with the strobe from its write task and samples the lookup outputs one nanosecond after the falling edge. Random upper words take their block address from a short list, and most random effective addresses are built from one of those addresses, so hits, overlaps between entries and near-misses with one flipped bit all occur often.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [31:0] EPI_MASK  = 32'hFFFE_0000;
  localparam logic [31:0] PAGE_MASK = 32'hFFFF_F000;
  localparam logic [31:0] STD_LEN_FIELD = 32'h0000_1FFC;
  localparam int unsigned STD_LEN_SHIFT = 15;
  localparam logic [31:0] LEG_LEN_FIELD = 32'h0000_003F;
  localparam int unsigned LEG_LEN_SHIFT = 17;
  localparam int unsigned STD_SUP_BIT = 1;
  localparam int unsigned STD_USR_BIT = 0;
  localparam int unsigned LEG_VLD_BIT = 6;
  localparam int unsigned LEG_KSUP_BIT = 3;
  localparam int unsigned LEG_KUSR_BIT = 2;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  function automatic perm_t std_perm(input logic [1:0] code);
    perm_t p;
    unique case (code)
      2'b00:   p = '{x: 1'b0, w: 1'b0, r: 1'b0};
      2'b10:   p = '{x: 1'b1, w: 1'b1, r: 1'b1};
      default: p = '{x: 1'b1, w: 1'b0, r: 1'b1};
    endcase
    return p;
  endfunction

  function automatic perm_t key_perm(input logic key, input logic [1:0] code);
    perm_t p;
    p.x = 1'b1;
    if (!key) begin
      p.r = 1'b1;
      p.w = (code != 2'b11);
    end else begin
      p.r = (code != 2'b00);
      p.w = (code == 2'b10);
    end
    return p;
  endfunction
endpackage

// File: rtl/blk_xlate_regs.sv
module blk_xlate_regs
  import blk_xlate_pkg::*;
#(
  parameter int unsigned NUM_ENT = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic                            wr_bank_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic                            wr_hi_i,
  input  logic [WORD_W-1:0]               wr_data_i,
  input  logic                            rd_bank_i,
  output logic [NUM_ENT-1:0][WORD_W-1:0]  rd_up_o,
  output logic [NUM_ENT-1:0][WORD_W-1:0]  rd_lo_o
);
  logic [1:0][NUM_ENT-1:0][WORD_W-1:0] up_q, lo_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      logic sel;
      assign sel = wr_en_i && (wr_bank_i == b[0]) && (wr_idx_i == IDX_W'(e));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          up_q[b][e] <= '0;
          lo_q[b][e] <= '0;
        end else if (sel) begin
          if (wr_hi_i) up_q[b][e] <= wr_data_i;
          else         lo_q[b][e] <= wr_data_i;
        end
      end
    end
  end

  assign rd_up_o = up_q[rd_bank_i];
  assign rd_lo_o = lo_q[rd_bank_i];

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(up_q) && $stable(lo_q)));
  p_upper_write_keeps_lower_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_hi_i) |=> $stable(lo_q));
  p_lower_write_keeps_upper_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hi_i) |=> $stable(up_q));
endmodule

// File: rtl/blk_xlate_entry.sv
module blk_xlate_entry
  import blk_xlate_pkg::*;
(
  input  logic [WORD_W-1:0] up_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] ea_i,
  input  logic              user_i,
  input  logic              legacy_i,
  output logic              match_o,
  output logic [WORD_W-1:0] ra_o,
  output perm_t             perm_o
);
  logic              usable;
  logic [WORD_W-1:0] len_sh, mask;

  always_comb begin
    if (legacy_i) begin
      usable = lo_i[LEG_VLD_BIT];
      len_sh = (lo_i & LEG_LEN_FIELD) << LEG_LEN_SHIFT;
      perm_o = key_perm(user_i ? up_i[LEG_KUSR_BIT] : up_i[LEG_KSUP_BIT], up_i[1:0]);
    end else begin
      usable = user_i ? up_i[STD_USR_BIT] : up_i[STD_SUP_BIT];
      len_sh = (up_i & STD_LEN_FIELD) << STD_LEN_SHIFT;
      perm_o = std_perm(lo_i[1:0]);
    end
    // unusable entry: zero mask, forced miss
    mask    = usable ? (EPI_MASK & ~len_sh) : '0;
    match_o = usable && ((ea_i & mask) == (up_i & EPI_MASK));
    ra_o    = ((lo_i & mask) | (ea_i & ~mask)) & PAGE_MASK;
  end
endmodule

// File: rtl/blk_xlate_pick.sv
module blk_xlate_pick #(
  parameter int unsigned NUM_ENT = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [NUM_ENT-1:0] match_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_ENT-1:0] grant_o
);
  always_comb begin
    hit_o   = 1'b0;
    idx_o   = '0;
    grant_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (match_i[i] && !hit_o) begin
        hit_o      = 1'b1;
        idx_o      = IDX_W'(i);
        grant_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/blk_xlate.sv
module blk_xlate
  import blk_xlate_pkg::*;
#(
  parameter int unsigned NUM_ENT = 4,
  localparam int unsigned IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              legacy_i,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_hi_i,
  input  logic [31:0]       wr_data_i,
  input  logic [31:0]       ea_i,
  input  logic              fetch_i,
  input  logic              user_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [31:0]       ra_o,
  output logic [2:0]        perm_o
);
  logic [NUM_ENT-1:0][WORD_W-1:0] up_w, lo_w, ra_w;
  perm_t [NUM_ENT-1:0]            perm_w;
  logic [NUM_ENT-1:0]             match_w, grant_w;

  blk_xlate_regs #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_bank_i, .wr_idx_i, .wr_hi_i, .wr_data_i,
    .rd_bank_i(fetch_i), .rd_up_o(up_w), .rd_lo_o(lo_w)
  );

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    blk_xlate_entry u_ent (
      .up_i(up_w[e]), .lo_i(lo_w[e]), .ea_i, .user_i, .legacy_i,
      .match_o(match_w[e]), .ra_o(ra_w[e]), .perm_o(perm_w[e])
    );
  end

  blk_xlate_pick #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_pick (
    .match_i(match_w), .hit_o, .idx_o(hit_idx_o), .grant_o(grant_w)
  );

  always_comb begin
    ra_o   = '0;
    perm_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      ra_o   = ra_o   | (grant_w[i] ? ra_w[i] : '0);
      perm_o = perm_o | (grant_w[i] ? perm_w[i] : 3'b000);
    end
  end

  p_grant_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_w));
  p_grant_lowest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_w[hit_idx_o] && ((match_w & ((NUM_ENT'(1) << hit_idx_o) - NUM_ENT'(1))) == '0)));
  p_page_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_o[11:0] == 12'h000);
  p_std_write_needs_rx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!legacy_i && perm_o[1]) |-> (perm_o[0] && perm_o[2]));
  p_legacy_exec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_i && hit_o) |-> perm_o[2]);
  p_miss_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (ra_o == '0 && perm_o == '0 && hit_idx_o == '0));
endmodule

// File: tb/sim_blk_xlate.sv
`timescale 1ns/1ps
module sim_blk_xlate;
  localparam int NE = 4;
  localparam int IW = 2;

  typedef struct packed {
    logic          hit;
    logic [IW-1:0] idx;
    logic [31:0]   ra;
    logic [2:0]    perm;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0, legacy_i = 1'b0;
  logic wr_en_i = 1'b0, wr_bank_i = 1'b0, wr_hi_i = 1'b0;
  logic [IW-1:0] wr_idx_i = '0;
  logic [31:0] wr_data_i = '0, ea_i = '0;
  logic fetch_i = 1'b0, user_i = 1'b0;
  logic hit_o;
  logic [IW-1:0] hit_idx_o;
  logic [31:0] ra_o;
  logic [2:0] perm_o;

  int n_vec = 0, n_bad = 0;
  logic [31:0] m_up [2][NE];
  logic [31:0] m_lo [2][NE];

  always #2 clk = ~clk;

  blk_xlate #(.NUM_ENT(NE)) u0 (
    .clk_i(clk), .rst_ni, .legacy_i, .wr_en_i, .wr_bank_i, .wr_idx_i, .wr_hi_i,
    .wr_data_i, .ea_i, .fetch_i, .user_i, .hit_o, .hit_idx_o, .ra_o, .perm_o
  );

  function automatic logic [2:0] exp_perm(logic leg, logic key, logic [1:0] code);
    if (!leg) begin
      case (code)
        2'b00: return 3'b000;
        2'b10: return 3'b111;
        default: return 3'b101;
      endcase
    end
    if (!key) return (code == 2'b11) ? 3'b101 : 3'b111;
    case (code)
      2'b00: return 3'b100;
      2'b10: return 3'b111;
      default: return 3'b101;
    endcase
  endfunction

  function automatic exp_t model(logic [31:0] ea, logic fet, logic usr, logic leg);
    exp_t r = '0;
    for (int i = 0; i < NE; i++) begin
      logic [31:0] u = m_up[fet ? 1 : 0][i];
      logic [31:0] l = m_lo[fet ? 1 : 0][i];
      logic v;
      logic [31:0] m;
      if (leg) begin
        v = l[6];
        m = 32'hFFFE0000 & ~({26'd0, l[5:0]} << 17);
      end else begin
        v = usr ? u[0] : u[1];
        m = 32'hFFFE0000 & ~({19'd0, u[12:2], 2'b00} << 15);
      end
      if (v && !r.hit && ((ea & m) == (u & 32'hFFFE0000))) begin
        r.hit  = 1'b1;
        r.idx  = IW'(i);
        r.ra   = ((l & m) | (ea & ~m)) & 32'hFFFFF000;
        r.perm = exp_perm(leg, usr ? u[2] : u[3], leg ? u[1:0] : l[1:0]);
      end
    end
    return r;
  endfunction

  task automatic chk(string tag);
    exp_t e = model(ea_i, fetch_i, user_i, legacy_i);
    n_vec++;
    if ({hit_o, hit_idx_o, ra_o, perm_o} !== e) begin
      n_bad++;
      $display("FAIL %s ea=%08h f=%0b u=%0b: got hit=%0b idx=%0d ra=%08h perm=%03b exp hit=%0b idx=%0d ra=%08h perm=%03b",
               tag, ea_i, fetch_i, user_i, hit_o, hit_idx_o, ra_o, perm_o, e.hit, e.idx, e.ra, e.perm);
    end
  endtask

  task automatic wr(logic bank, int idx, logic hi, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_bank_i = bank; wr_idx_i = IW'(idx); wr_hi_i = hi; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (hi) m_up[bank][idx] = d; else m_lo[bank][idx] = d;
  endtask

  task automatic look(logic [31:0] ea, logic fet, logic usr, string tag);
    @(negedge clk);
    ea_i = ea; fetch_i = fet; user_i = usr;
    #1 chk(tag);
  endtask

  task automatic clear_all();
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NE; i++) begin
        wr(b[0], i, 1'b1, 32'h0);
        wr(b[0], i, 1'b0, 32'h0);
      end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] bepi_set [4];
    void'($urandom(32'd4711));
    bepi_set[0] = 32'h1000_0000; bepi_set[1] = 32'h4002_0000;
    bepi_set[2] = 32'hC000_0000; bepi_set[3] = 32'h0FFE_0000;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NE; i++) begin m_up[b][i] = '0; m_lo[b][i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10: empty after reset, both layouts
    look(32'h0000_0000, 1'b0, 1'b0, "R10");
    look(32'hFFFF_FFFF, 1'b1, 1'b1, "R10");
    legacy_i = 1'b1;
    look(32'h1234_5678, 1'b0, 1'b0, "R10");
    legacy_i = 1'b0;
    // R11 miss with zero outputs
    look(32'h8000_0000, 1'b0, 1'b1, "R11");

    // R4 / R5: 2 MB block at 0x1000_0000 -> 0x8000_0000, data bank entry 1
    wr(1'b0, 1, 1'b1, 32'h1000_003F);
    wr(1'b0, 1, 1'b0, 32'h8000_0002);
    look(32'h101F_F123, 1'b0, 1'b0, "R5");
    look(32'h1000_0FFF, 1'b0, 1'b1, "R4");
    look(32'h1020_0000, 1'b0, 1'b0, "R4");
    // R1: fetch must search empty instruction bank
    look(32'h101F_F123, 1'b1, 1'b0, "R1");
    wr(1'b1, 3, 1'b1, 32'h1000_0003);
    wr(1'b1, 3, 1'b0, 32'h2000_0001);
    look(32'h1001_2345, 1'b1, 1'b0, "R1");
    look(32'h1001_2345, 1'b0, 1'b0, "R1");
    // R3: supervisor-only entry
    wr(1'b0, 1, 1'b1, 32'h1000_003E);
    look(32'h1000_5000, 1'b0, 1'b1, "R3");
    look(32'h1000_5000, 1'b0, 1'b0, "R3");
    wr(1'b0, 1, 1'b1, 32'h1000_003D);
    look(32'h1000_5000, 1'b0, 1'b1, "R3");
    look(32'h1000_5000, 1'b0, 1'b0, "R3");
    // R2: overlapping entries 0 and 1, lowest wins
    wr(1'b0, 1, 1'b1, 32'h1000_003F);
    wr(1'b0, 0, 1'b1, 32'h1000_0003);
    wr(1'b0, 0, 1'b0, 32'h9000_0001);
    look(32'h1000_7000, 1'b0, 1'b0, "R2");
    look(32'h1005_7000, 1'b0, 1'b0, "R2");
    // R6: all permission codes
    for (int pp = 0; pp < 4; pp++) begin
      wr(1'b0, 0, 1'b0, 32'h9000_0000 | pp);
      look(32'h1000_1000, 1'b0, 1'b0, "R6");
    end
    // R12: write visible only after the capturing edge
    @(negedge clk);
    wr_en_i = 1'b1; wr_bank_i = 1'b0; wr_idx_i = 2; wr_hi_i = 1'b1; wr_data_i = 32'hC000_0003;
    ea_i = 32'hC001_0000; fetch_i = 1'b0; user_i = 1'b0;
    #1 chk("R12");
    @(negedge clk);
    wr_en_i = 1'b0; m_up[0][2] = 32'hC000_0003;
    #1 chk("R12");
    // R9: instruction-bank and lower-word writes leave data entry 2 upper intact
    wr(1'b1, 2, 1'b1, 32'h0);
    wr(1'b0, 2, 1'b0, 32'h5000_0002);
    look(32'hC001_0000, 1'b0, 1'b0, "R9");
    wr(1'b0, 3, 1'b1, 32'hFFFF_FFFF);
    look(32'hC001_0000, 1'b0, 1'b0, "R9");

    // R7 / R8: legacy layout
    clear_all();
    legacy_i = 1'b1;
    wr(1'b0, 0, 1'b0, 32'h7000_0040 | 32'h3);   // valid, len 3 -> 512 KB
    for (int k = 0; k < 16; k++) begin
      wr(1'b0, 0, 1'b1, 32'h3000_0000 | k);
      look(32'h3007_A000, 1'b0, 1'b0, "R8");
      look(32'h3007_A000, 1'b0, 1'b1, "R8");
    end
    look(32'h3008_0000, 1'b0, 1'b0, "R7");
    wr(1'b0, 0, 1'b0, 32'h7000_0003);           // valid cleared
    look(32'h3001_0000, 1'b0, 1'b1, "R7");

    // random phase, both layouts
    for (int ph = 0; ph < 2; ph++) begin
      legacy_i = ph[0];
      for (int rnd = 0; rnd < 40; rnd++) begin
        for (int w = 0; w < 4; w++) begin
          logic [31:0] up, lo;
          up = bepi_set[$urandom_range(0, 3)] | ($urandom & 32'h0001_FFFF);
          if ($urandom_range(0, 1) == 0) up = (up & ~32'h1FFC) | (({$urandom} % 4) == 0 ? 32'h1FFC : 32'h001C);
          lo = $urandom;
          wr($urandom_range(0, 1) == 1, $urandom_range(0, NE - 1), 1'b1, up);
          wr($urandom_range(0, 1) == 1, $urandom_range(0, NE - 1), 1'b0, lo);
        end
        for (int v = 0; v < 25; v++) begin
          logic [31:0] ea;
          case ($urandom_range(0, 3))
            0: ea = $urandom;
            1: ea = bepi_set[$urandom_range(0, 3)] ^ (32'h1 << $urandom_range(17, 31));
            default: ea = bepi_set[$urandom_range(0, 3)] | ($urandom & 32'h0FFF_FFFF & ~32'h0FFE_0000) | ($urandom & 32'h0FE0_0000);
          endcase
          look(ea, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, ph ? "R8" : "R6");
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule